// File: doc/BRIEF.md
# Composite Sync Vertical Pulse Separator

This block recovers a vertical sync indication from a composite sync stream. Polarity is fixed to active-high before the stream arrives here. The input is first resynchronised into the system clock domain. An up/down integrator counter then measures it, advancing only on a clock-enable tick of roughly 5 MHz, so one count is about 200 ns. Horizontal sync pulses are short and the low time between them is long, so the count never climbs past a threshold. A vertical sync pulse is long, so the count does climb past it.

Once vertical sync is flagged, the counter starts again from zero and integrates in the opposite direction. It counts up while the sync is absent and down while it is present. Vertical sync is released only when the absence has built up to the same threshold. The short serration gaps inside the vertical pulse, and the short equalising pulses after it, therefore cannot end or restart the indication. The threshold comes from an input and is captured only while the counter rests at zero. A separate flag reports whether the sync input has toggled recently.

Top module: `csync_vsep`

## Requirements
- R1: The integrator count and the vertical sync output change only on clock cycles in which `tick_en` is high. The synchronised sync level may sit still for any number of cycles without a tick, and neither the count nor the output moves.
- R2: While searching (vertical sync low), each tick with sync high raises the count by one, up to a ceiling of 255. Each tick with sync low lowers it by one, down to a floor of 0. Repeated pulses of 20 ticks high separated by 30 ticks low, with threshold 32, never assert vertical sync.
- R3: Vertical sync rises on the tick where the updated search count would exceed the threshold T (count > T). On that tick the counter is cleared to 0. With T = 0, a single high tick asserts it.
- R4: While vertical sync is high, each tick with sync low raises the count by one (ceiling 255). Each tick with sync high lowers it by one (floor 0). Vertical sync falls on the tick where the updated count reaches T (count >= T), and the counter is cleared to 0. Short high pulses and short low gaps therefore neither end nor restart the pulse early. With T = 0, the next tick after assertion always releases it.
- R5: The threshold used for comparison is loaded from `thresh_in` only while the count is 0. A change made while the count is non-zero has no effect until the count returns to 0. The reset value of the threshold is 32.
- R6: With T = 255, vertical sync never asserts, however long the sync stays high, because the count cannot exceed 255.
- R7: `active_out` goes high when the synchronised sync level toggles. It goes low on the 2^ACT_WIN_W-th tick after the last toggle if no toggle has happened in between. ACT_WIN_W defaults to 16, a window of 65536 ticks.
- R8: After reset, `vsync_out` and `active_out` are 0 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counting enable, one-cycle pulse about every 200 ns |
| csync_in | input | 1 | Composite sync, active-high, asynchronous |
| thresh_in | input | CNT_W | Integrator threshold T |
| vsync_out | output | 1 | Separated vertical sync, active-high |
| active_out | output | 1 | Sync input has toggled within the activity window |

## Verification
The hardest case to reach from the ports is a threshold change that must be ignored. This only happens while the hidden count is non-zero. The stimulus first builds the count to a known value with ten high ticks and then lowers the threshold far enough that an immediate load would assert vertical sync. It keeps the sync high, so that a wrongly loaded threshold shows up on `vsync_out`. It then drains the count to zero and confirms that the new threshold is now in force. Equalising and serration behaviour is driven with patterns whose net integral stays below the threshold, so that only a correct two-phase integrator holds the output steady.

// File: rtl/csv_pkg.sv
package csv_pkg;
    typedef enum logic {
        PH_SEEK = 1'b0,
        PH_HOLD = 1'b1
    } phase_e;
endpackage

// File: rtl/csv_sync.sv
module csv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/csv_integrator.sv
module csv_integrator
    import csv_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int THR_DEFAULT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             vsync_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] thr_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] THR_RST = CNT_W'(THR_DEFAULT);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] thr;
    } integ_t;

    integ_t st_d, st_q;
    logic   toward_hit;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        st_d       = st_q;
        toward_hit = (st_q.ph == PH_SEEK) ? sync_i : !sync_i;
        if (toward_hit) nxt = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + 1'b1;
        else            nxt = (st_q.cnt == '0)      ? st_q.cnt : st_q.cnt - 1'b1;

        if (st_q.cnt == '0) st_d.thr = thr_i;

        if (tick_i) begin
            if (st_q.ph == PH_SEEK) begin
                if (nxt > st_q.thr) begin
                    st_d.ph  = PH_HOLD;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = nxt;
                end
            end else begin
                if (nxt >= st_q.thr) begin
                    st_d.ph  = PH_SEEK;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = nxt;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_SEEK, cnt: '0, thr: THR_RST};
        else        st_q <= st_d;
    end

    assign vsync_o = (st_q.ph == PH_HOLD);
    assign cnt_o   = st_q.cnt;
    assign thr_o   = st_q.thr;
endmodule

// File: rtl/csv_activity.sv
module csv_activity #(
    parameter int WIN_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sync_i,
    output logic active_o
);
    localparam logic [WIN_W-1:0] IDLE_MAX = {WIN_W{1'b1}};

    typedef struct packed {
        logic             active;
        logic             prev;
        logic [WIN_W-1:0] idle;
    } act_t;

    act_t st_d, st_q;
    logic toggled;

    always_comb begin
        st_d      = st_q;
        toggled   = sync_i ^ st_q.prev;
        st_d.prev = sync_i;
        if (toggled) begin
            st_d.idle   = '0;
            st_d.active = 1'b1;
        end else if (tick_i) begin
            if (st_q.idle == IDLE_MAX) st_d.active = 1'b0;
            else                       st_d.idle   = st_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b0, prev: 1'b0, idle: '0};
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
endmodule

// File: rtl/csync_vsep.sv
module csync_vsep #(
    parameter int CNT_W       = 8,
    parameter int THR_DEFAULT = 32,
    parameter int ACT_WIN_W   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             csync_in,
    input  logic [CNT_W-1:0] thresh_in,
    output logic             vsync_out,
    output logic             active_out
);
    logic             sync_s;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] thr_w;

    csv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (csync_in),
        .sync_o  (sync_s)
    );

    csv_integrator #(.CNT_W(CNT_W), .THR_DEFAULT(THR_DEFAULT)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_en),
        .sync_i  (sync_s),
        .thr_i   (thresh_in),
        .vsync_o (vsync_out),
        .cnt_o   (cnt_w),
        .thr_o   (thr_w)
    );

    csv_activity #(.WIN_W(ACT_WIN_W)) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_en),
        .sync_i   (sync_s),
        .active_o (active_out)
    );
endmodule

// File: rtl/csync_vsep_chk.sv
module csync_vsep_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             vsync_out,
    input logic             active_out,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] thr
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    a_r1_count_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt));

    a_r1_vsync_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(vsync_out));

    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX) |=> (cnt == CMAX || cnt == CMAX - 1'b1 || cnt == '0));

    a_r3_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_out) |-> (cnt == '0));

    a_r4_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_out) |-> (cnt == '0));

    a_r5_thr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> $stable(thr));

    a_r7_idle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_out) |-> $past(tick_en));
endmodule

bind csync_vsep csync_vsep_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .vsync_out  (vsync_out),
    .active_out (active_out),
    .cnt        (cnt_w),
    .thr        (thr_w)
);

// File: tb/csync_vsep_tb.sv
module csync_vsep_tb;
    localparam int CNT_W   = 8;
    localparam int WIN_W   = 8;
    localparam int IDLE_LIM = (1 << WIN_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic csync_in = 1'b0;
    logic [CNT_W-1:0] thresh_in = 8'd32;
    logic vsync_out, active_out;

    always #4 clk = ~clk;

    csync_vsep #(.CNT_W(CNT_W), .THR_DEFAULT(32), .ACT_WIN_W(WIN_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .csync_in(csync_in),
        .thresh_in(thresh_in), .vsync_out(vsync_out), .active_out(active_out)
    );

    typedef struct {
        bit    vs;
        bit    act;
        string tag;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_bad = 0;

    int m_cnt = 0, m_thr = 32, m_idle = 0;
    bit m_vs = 0, m_act = 0, m_prev = 0;

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick_drive(input bit s, input string tag);
        exp_t e;
        int   n;
        csync_in = s;
        if (s != m_prev) begin m_idle = 0; m_act = 1; end
        m_prev = s;
        repeat (3) @(negedge clk);
        if (m_cnt == 0) m_thr = int'(thresh_in);
        if (!m_vs) begin
            n = s ? ((m_cnt == 255) ? 255 : m_cnt + 1) : ((m_cnt == 0) ? 0 : m_cnt - 1);
            if (n > m_thr) begin m_vs = 1; m_cnt = 0; end else m_cnt = n;
        end else begin
            n = !s ? ((m_cnt == 255) ? 255 : m_cnt + 1) : ((m_cnt == 0) ? 0 : m_cnt - 1);
            if (n >= m_thr) begin m_vs = 0; m_cnt = 0; end else m_cnt = n;
        end
        if (m_idle == IDLE_LIM) m_act = 0; else m_idle++;
        e.vs = m_vs; e.act = m_act; e.tag = tag;
        sb.push_back(e);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic run(input bit s, input int cnt, input string tag);
        for (int i = 0; i < cnt; i++) tick_drive(s, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            if (tick_en) begin
                @(negedge clk);
                e = sb.pop_front();
                check(vsync_out == e.vs, {e.tag, " vsync"}, int'(vsync_out), int'(e.vs));
                check(active_out == e.act, {e.tag, " active(R7)"}, int'(active_out), int'(e.act));
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(vsync_out == 1'b0, "R8 vsync after reset", int'(vsync_out), 0);
        check(active_out == 1'b0, "R8 active after reset", int'(active_out), 0);

        // R2: horizontal-like pulses stay below threshold 32
        for (int k = 0; k < 4; k++) begin
            run(1, 20, "R2");
            run(0, 30, "R2");
        end

        // R1: count sits at 32; no ticks must leave vsync low
        run(1, 32, "R1");
        repeat (40) @(negedge clk);
        check(vsync_out == 1'b0, "R1 no tick no change", int'(vsync_out), 0);
        // R3: one more high tick exceeds 32
        run(1, 1, "R3");

        // R4: serrations inside the pulse, then equalising pulses, then release
        for (int k = 0; k < 3; k++) begin
            run(0, 4, "R4");
            run(1, 20, "R4");
        end
        for (int k = 0; k < 3; k++) begin
            run(1, 2, "R4");
            run(0, 10, "R4");
        end
        run(0, 12, "R4");

        // R5: threshold change while count non-zero is ignored
        run(0, 5, "R5");
        run(1, 10, "R5");
        thresh_in = 8'd5;
        run(1, 10, "R5");
        run(0, 25, "R5");
        run(1, 6, "R5");
        run(0, 5, "R5");

        // R6: threshold 255 never asserts
        thresh_in = 8'd255;
        run(0, 2, "R6");
        run(1, 300, "R6");
        run(0, 300, "R6");

        // R3/R4 boundary: threshold 0
        thresh_in = 8'd0;
        run(0, 2, "R3");
        run(1, 1, "R3");
        run(1, 1, "R4");

        // R7: activity window expiry and recovery
        run(0, 260, "R7");
        run(1, 1, "R7");
        run(1, 3, "R7");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R1 scoreboard drained", sb.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule